// File: doc/BRIEF.md
# Predicated Instruction Window Sequencer

This block lets a compact 16-bit instruction decoder attach a condition code to instructions whose own encoding has no room for one. A predicate-setting instruction supplies a 4-bit base condition and a pattern that marks each of up to three further instructions as "same as base" (then) or "opposite of base" (else). The block packs that into an 8-bit state word: the upper three bits of the base condition select a flag test, and a 5-bit shifting tail holds the low condition bit for the current instruction, the remaining per-instruction low bits and a single stop marker.

Every time the decoder issues an instruction, the sequencer presents that instruction's effective 4-bit condition and then advances the tail. The window closes after the last covered instruction. The block also says whether the current instruction lies inside a window, evaluates the current condition against the N, Z, C, V flags, and reports a nested load or an always-condition pattern that asks for an else slot.

Top module: `pred_window_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) in_block is 0, cur_cond is 4'hE (always), cond_pass is 1 and both error outputs are 0.
- R2: A legal load accepted while outside a window opens a window on the next edge, and the first covered instruction's cur_cond equals load_cond exactly.
- R3: Covered instruction k+2 (k = 0..2) uses the base condition when pat_else[k] is 0 and the base condition with bit 0 inverted when pat_else[k] is 1; the upper three bits never change inside a window.
- R4: A window covers exactly 1 + pat_len instructions; after that many issue pulses in_block is 0 and cur_cond is 4'hE.
- R5: While inside a window, a cycle with issue low leaves cur_cond and in_block unchanged.
- R6: A load presented while in_block is 1 is ignored (the window and its conditions continue unchanged) and nest_err is 1 for exactly the following cycle.
- R7: A load with load_cond 4'hE and any live slot (k < pat_len) marked else is rejected: no window opens and always_err is 1 for exactly the following cycle.
- R8: Inside a window, cond_pass follows the condition on flags_nzcv (bit 3 N, bit 2 Z, bit 1 C, bit 0 V): cur_cond[3:1] 0 Z, 1 C, 2 N, 3 V, 4 C and not Z, 5 N equals V, 6 not Z and N equals V; bit 0 set inverts the test; cur_cond[3:1] of 7 always passes.
- R9: Outside a window cond_pass is 1 for every flag value, and issue pulses change nothing.
- R10: Base 4'h0 with pat_len 3 and pat_else 3'b010 yields conditions 0, 0, 1, 0 for four successive instructions.
- R11: pat_else bits at positions k >= pat_len have no effect on conditions, on window length or on the always-condition check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Predicate-setting instruction present this cycle |
| load_cond | input | 4 | Base condition code |
| pat_len | input | 2 | Number of instructions covered beyond the first (0..3) |
| pat_else | input | 3 | Bit k marks instruction k+2 as else |
| issue | input | 1 | One instruction issues this cycle |
| flags_nzcv | input | 4 | Current N, Z, C, V flags |
| in_block | output | 1 | Current instruction lies inside a window |
| cur_cond | output | 4 | Effective condition of the current instruction |
| cond_pass | output | 1 | Current instruction should execute |
| nest_err | output | 1 | Pulse: load arrived inside a window |
| always_err | output | 1 | Pulse: always-condition load asked for an else slot |

## Verification
Windows of every length with all-then letters separate a wrong stop-marker position from a wrong shift, while all eight else patterns on one base show which slot's bit drives which instruction. The four-instruction then-then-else-then example and patterns with stray bits beyond the length tell apart an encoder that honours dead slots from one that masks them. Every base condition is crossed with all sixteen flag values to pin down the flag mapping and the inversion, and loads during an open window or with an always base and an else letter check that rejection leaves the running conditions untouched.

// File: rtl/pw_pkg.sv
// pw_pkg: shared constants and types for the predicated window sequencer.
// Assumes a 4-bit condition code whose upper three bits select a flag
// test and whose low bit selects that test or its opposite.
package pw_pkg;
    localparam int COND_W    = 4;
    localparam int TEST_W    = COND_W - 1;
    localparam int MAX_EXTRA = 3;
    localparam int TAIL_W    = MAX_EXTRA + 2;
    localparam int ST_W      = TEST_W + TAIL_W;
    localparam int LEN_W     = $clog2(MAX_EXTRA + 1);
    localparam int FLAG_W    = 4;

    localparam logic [COND_W-1:0] COND_ALWAYS = COND_W'(4'hE);

    typedef enum logic [TEST_W-1:0] {
        TST_Z      = 3'd0,
        TST_C      = 3'd1,
        TST_N      = 3'd2,
        TST_V      = 3'd3,
        TST_HI     = 3'd4,
        TST_GE     = 3'd5,
        TST_GT     = 3'd6,
        TST_ALWAYS = 3'd7
    } test_e;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic [TAIL_W-1:0] tail;
    } pw_state_t;
endpackage

// File: rtl/pw_pack.sv
// pw_pack: turns a base condition and then/else pattern into the packed
// window state. Purely combinational. Assumes pat_len counts covered
// instructions beyond the first; larger values are clamped to MAX_EXTRA.
module pw_pack
    import pw_pkg::*;
(
    input  logic [COND_W-1:0]    load_cond,
    input  logic [LEN_W-1:0]     pat_len,
    input  logic [MAX_EXTRA-1:0] pat_else,
    output pw_state_t            packed_st,
    output logic                 bad_always
);
    logic [LEN_W-1:0]     len_eff;
    logic [MAX_EXTRA-1:0] live;

    // Clamp the requested length to the slots that exist.
    always_comb begin
        if (pat_len > LEN_W'(MAX_EXTRA)) len_eff = LEN_W'(MAX_EXTRA);
        else                             len_eff = pat_len;
    end

    // Mark which pattern slots are inside the requested length.
    for (genvar k = 0; k < MAX_EXTRA; k++) begin : g_live
        assign live[k] = (LEN_W'(k) < len_eff);
    end

    // Build the tail: current low bit, live low bits, stop marker, zeros.
    always_comb begin
        packed_st.test             = load_cond[COND_W-1:1];
        packed_st.tail             = '0;
        packed_st.tail[TAIL_W-1]   = load_cond[0];
        for (int k = 0; k < MAX_EXTRA; k++) begin
            if (live[k]) packed_st.tail[TAIL_W-2-k] = load_cond[0] ^ pat_else[k];
        end
        packed_st.tail[TAIL_W-2-int'(len_eff)] = 1'b1;
    end

    // An always base may not ask for an inverted slot.
    assign bad_always = (load_cond == COND_ALWAYS) && |(pat_else & live);
endmodule

// File: rtl/pw_track.sv
// pw_track: holds the packed window state and advances it on each issued
// instruction. Assumes load_ok is only raised when no window is open.
module pw_track
    import pw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_ok,
    input  pw_state_t load_st,
    input  logic      issue,
    output pw_state_t st,
    output logic      in_blk,
    output logic      last
);
    // Window is open while the stop marker sits below the current bit.
    assign in_blk = |st.tail[TAIL_W-2:0];
    // Current instruction is the final one when the marker is next in line.
    assign last   = in_blk && (st.tail[TAIL_W-3:0] == '0);

    // State register: load, shift on issue, clear after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (load_ok) begin
            st <= load_st;
        end else if (issue && in_blk) begin
            if (last) st <= '0;
            else      st.tail <= {st.tail[TAIL_W-2:0], 1'b0};
        end
    end

    AST_LAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk && last && issue && !load_ok) |=> !in_blk); // R4

    AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk && !issue && !load_ok) |=> ($stable(st) && in_blk)); // R5

    AST_TEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk && !last && issue && !load_ok) |=> (in_blk && st.test == $past(st.test))); // R3
endmodule

// File: rtl/pw_eval.sv
// pw_eval: decides whether a condition code passes on the given flags.
// Combinational. Assumes flags are ordered N, Z, C, V from the top bit.
module pw_eval
    import pw_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] nzcv,
    output logic              pass
);
    logic  fn, fz, fc, fv;
    logic  raw;
    test_e tsel;

    assign {fn, fz, fc, fv} = nzcv;
    assign tsel = test_e'(cond[COND_W-1:1]);

    // Base flag test selected by the upper condition bits.
    always_comb begin
        unique case (tsel)
            TST_Z:      raw = fz;
            TST_C:      raw = fc;
            TST_N:      raw = fn;
            TST_V:      raw = fv;
            TST_HI:     raw = fc && !fz;
            TST_GE:     raw = (fn == fv);
            TST_GT:     raw = !fz && (fn == fv);
            TST_ALWAYS: raw = 1'b1;
            default:    raw = 1'b1;
        endcase
    end

    // Low bit inverts every test except the always group.
    assign pass = (tsel == TST_ALWAYS) ? 1'b1 : (raw ^ cond[0]);
endmodule

// File: rtl/pred_window_seq.sv
// pred_window_seq: predicated instruction window sequencer. Accepts a
// base condition plus then/else pattern, supplies each following issued
// instruction with its condition, and flags illegal loads. Assumes at most
// one load and one issue per cycle; flags are valid in the issue cycle.
module pred_window_seq
    import pw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_valid,
    input  logic [COND_W-1:0]    load_cond,
    input  logic [LEN_W-1:0]     pat_len,
    input  logic [MAX_EXTRA-1:0] pat_else,
    input  logic                 issue,
    input  logic [FLAG_W-1:0]    flags_nzcv,
    output logic                 in_block,
    output logic [COND_W-1:0]    cur_cond,
    output logic                 cond_pass,
    output logic                 nest_err,
    output logic                 always_err
);
    pw_state_t packed_st;
    pw_state_t st;
    logic      bad_always;
    logic      in_blk;
    logic      last;
    logic      load_ok;
    logic      eval_pass;

    pw_pack u_pack (
        .load_cond  (load_cond),
        .pat_len    (pat_len),
        .pat_else   (pat_else),
        .packed_st  (packed_st),
        .bad_always (bad_always)
    );

    // Accept a load only outside a window and with a legal pattern.
    assign load_ok = load_valid && !in_blk && !bad_always;

    pw_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_ok (load_ok),
        .load_st (packed_st),
        .issue   (issue),
        .st      (st),
        .in_blk  (in_blk),
        .last    (last)
    );

    // Unpack the current condition; outside a window report always.
    assign cur_cond = in_blk ? {st.test, st.tail[TAIL_W-1]} : COND_ALWAYS;
    assign in_block = in_blk;

    pw_eval u_eval (
        .cond (cur_cond),
        .nzcv (flags_nzcv),
        .pass (eval_pass)
    );

    // Outside a window every instruction executes.
    assign cond_pass = in_blk ? eval_pass : 1'b1;

    // One-cycle error pulses for rejected loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nest_err   <= 1'b0;
            always_err <= 1'b0;
        end else begin
            nest_err   <= load_valid && in_blk;
            always_err <= load_valid && !in_blk && bad_always;
        end
    end

    AST_LOAD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (in_block && cur_cond == $past(load_cond))); // R2

    AST_NEST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && in_block) |=> (nest_err && !always_err)); // R6

    AST_NEST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && in_block && !issue) |=> $stable(cur_cond)); // R6

    AST_ALWAYS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !in_block && load_cond == COND_ALWAYS && bad_always) |=> (!in_block && always_err)); // R7

    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block |-> cond_pass); // R9
endmodule

// File: tb/pred_window_seq_tb.sv
module pred_window_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_valid = 1'b0;
    logic [3:0] load_cond = 4'h0;
    logic [1:0] pat_len = 2'd0;
    logic [2:0] pat_else = 3'd0;
    logic       issue = 1'b0;
    logic [3:0] flags_nzcv = 4'h0;
    logic       in_block;
    logic [3:0] cur_cond;
    logic       cond_pass;
    logic       nest_err;
    logic       always_err;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pred_window_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_cond  (load_cond),
        .pat_len    (pat_len),
        .pat_else   (pat_else),
        .issue      (issue),
        .flags_nzcv (flags_nzcv),
        .in_block   (in_block),
        .cur_cond   (cur_cond),
        .cond_pass  (cond_pass),
        .nest_err   (nest_err),
        .always_err (always_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cf, v, r;
        n = f[3]; z = f[2]; cf = f[1]; v = f[0];
        case (c[3:1])
            3'd0: r = z;
            3'd1: r = cf;
            3'd2: r = n;
            3'd3: r = v;
            3'd4: r = cf && !z;
            3'd5: r = (n == v);
            3'd6: r = !z && (n == v);
            default: return 1'b1;
        endcase
        return r ^ c[0];
    endfunction

    // Inputs change and outputs are sampled 2 ns after a rising edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_load(input logic [3:0] c, input logic [1:0] l, input logic [2:0] e);
        load_valid = 1'b1; load_cond = c; pat_len = l; pat_else = e;
        tick();
        load_valid = 1'b0;
    endtask

    task automatic do_issue();
        issue = 1'b1;
        tick();
        issue = 1'b0;
    endtask

    task automatic expect_cond(input string req, input logic [3:0] exp);
        chk(in_block === 1'b1, req, "in_block", int'(in_block), 1);
        chk(cur_cond === exp, req, "cur_cond", int'(cur_cond), int'(exp));
    endtask

    task automatic expect_out(input string req);
        chk(in_block === 1'b0, req, "in_block out", int'(in_block), 0);
        chk(cur_cond === 4'hE, req, "cur_cond out", int'(cur_cond), 14);
    endtask

    task automatic t_reset();
        tick(); tick();
        chk(in_block === 1'b0, "R1", "in_block", int'(in_block), 0);
        chk(cur_cond === 4'hE, "R1", "cur_cond", int'(cur_cond), 14);
        chk(cond_pass === 1'b1, "R1", "cond_pass", int'(cond_pass), 1);
        chk(nest_err === 1'b0 && always_err === 1'b0, "R1", "errors", int'({nest_err, always_err}), 0);
        rst_n = 1'b1;
        tick();
        expect_out("R1");
    endtask

    task automatic t_example();
        logic [3:0] seq [4] = '{4'h0, 4'h0, 4'h1, 4'h0};
        do_load(4'h0, 2'd3, 3'b010);
        for (int i = 0; i < 4; i++) begin
            expect_cond("R10", seq[i]);
            do_issue();
        end
        expect_out("R10");
    endtask

    task automatic t_lengths();
        for (int l = 0; l < 4; l++) begin
            do_load(4'h1, 2'(l), 3'b000);
            expect_cond("R2", 4'h1);
            for (int i = 0; i <= l; i++) begin
                expect_cond("R4", 4'h1);
                do_issue();
            end
            expect_out("R4");
        end
    endtask

    task automatic t_else_patterns();
        for (int e = 0; e < 8; e++) begin
            do_load(4'h2, 2'd3, 3'(e));
            expect_cond("R3", 4'h2);
            do_issue();
            for (int k = 0; k < 3; k++) begin
                expect_cond("R3", {3'b001, e[k]});
                do_issue();
            end
            expect_out("R3");
        end
    endtask

    task automatic t_hold();
        do_load(4'hA, 2'd2, 3'b001);
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_cond("R5", 4'hA);
        end
        do_issue();
        expect_cond("R5", 4'hB);
        tick(); tick();
        expect_cond("R5", 4'hB);
        do_issue();
        expect_cond("R5", 4'hA);
        do_issue();
        expect_out("R5");
    endtask

    task automatic t_nest();
        do_load(4'h0, 2'd1, 3'b000);
        do_load(4'h4, 2'd3, 3'b111);
        chk(nest_err === 1'b1, "R6", "nest_err pulse", int'(nest_err), 1);
        expect_cond("R6", 4'h0);
        tick();
        chk(nest_err === 1'b0, "R6", "nest_err clear", int'(nest_err), 0);
        do_issue();
        expect_cond("R6", 4'h0);
        do_issue();
        expect_out("R6");
    endtask

    task automatic t_always();
        do_load(4'hE, 2'd2, 3'b010);
        chk(always_err === 1'b1, "R7", "always_err pulse", int'(always_err), 1);
        expect_out("R7");
        tick();
        chk(always_err === 1'b0, "R7", "always_err clear", int'(always_err), 0);
        do_load(4'hE, 2'd2, 3'b100);
        chk(always_err === 1'b0, "R11", "dead slot no error", int'(always_err), 0);
        for (int i = 0; i < 3; i++) begin
            expect_cond("R11", 4'hE);
            do_issue();
        end
        expect_out("R11");
        do_load(4'hC, 2'd1, 3'b110);
        for (int i = 0; i < 2; i++) begin
            expect_cond("R11", 4'hC);
            do_issue();
        end
        expect_out("R11");
    endtask

    task automatic t_eval();
        for (int c = 0; c < 16; c++) begin
            do_load(4'(c), 2'd0, 3'b000);
            for (int f = 0; f < 16; f++) begin
                flags_nzcv = 4'(f);
                #1;
                chk(cond_pass === ref_pass(4'(c), 4'(f)), "R8", $sformatf("pass c=%0d f=%0d", c, f),
                    int'(cond_pass), int'(ref_pass(4'(c), 4'(f))));
            end
            do_issue();
        end
        for (int f = 0; f < 16; f++) begin
            flags_nzcv = 4'(f);
            #1;
            chk(cond_pass === 1'b1, "R9", "pass outside", int'(cond_pass), 1);
        end
        do_issue();
        expect_out("R9");
    endtask

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_lengths();
        t_else_patterns();
        t_hold();
        t_nest();
        t_always();
        t_eval();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule